// File: doc/BRIEF.md
# Programmed-I/O Bus Cycle Sequencer

This block runs one host-side programmed-I/O transfer on a parallel peripheral bus at a time. A request carries a direction, an address, write data and a speed grade from 0 to 4. The block drives the address onto the bus, lowers exactly one of two active-low strobes (read or write), and enables its data drivers for writes. It then returns the captured read data together with a one-cycle completion pulse.

Each speed grade fixes four minimum intervals: address setup before the strobe falls, strobe width, strobe recovery and total cycle length. Each is held as a whole number of system clocks, obtained by rounding the nanosecond figure up at a 10 ns clock. The total cycle is enforced on its own terms, so recovery is lengthened when width plus recovery would otherwise fall short. The attached device can hold off completion by pulling a ready line low. The block keeps the strobe down while that line is low, but only up to a fixed limit, after which it ends the transfer and flags an error.

Top module: `pio_cycle_timer`

## Requirements
- R1: While reset is asserted and after it is released, both strobes are high, the data drivers are off, and `done_o` and `err_o` are low.
- R2: A request is taken only in a cycle where no transfer is running. The direction, address, write data and speed grade are latched at that edge. A request or a grade change arriving during a transfer has no effect on it, and the bus address stays at the latched value until the next request is taken.
- R3: The strobe falls S clock edges after the accepting edge, where S is 7, 5, 3, 3, 3 for grades 0 to 4.
- R4: Without a hold-off, the strobe stays low for exactly W cycles, where W is 17, 13, 10, 8, 7 for grades 0 to 4.
- R5: The completion edge comes max(C, L + Q) cycles after the strobe falls. Here L is the actual low time and C is 60, 39, 24, 18, 12. Q is the largest of the recovery minimum (0, 0, 0, 7, 3), the address hold (2, 2, 1, 1, 1), the data hold (3, 2, 2, 1, 1) and 1, all for grades 0 to 4.
- R6: `wr_i` = 1 selects a write. A write lowers only `bus_wr_n_o`, and the drivers stay on with the latched data from acceptance to completion. A read lowers only `bus_rd_n_o` with the drivers off.
- R7: From the W-th low cycle onward, the strobe rises only at an edge where `iordy_i` is high. A ready line that goes high at edge k ≥ W gives a low time of k.
- R8: If `iordy_i` is still low at the 125th edge of the wait (low time W + 124), the strobe rises anyway and `err_o` is raised together with `done_o`. Ready rising at exactly that edge gives no error.
- R9: For a read, `rdata_o` takes `bus_rdata_i` at the edge where the strobe rises and keeps it until the next read capture.
- R10: `done_o` is high for exactly one cycle per transfer, after the strobe has returned high. `err_o` is never high without `done_o`.
- R11: Speed grades 5 to 7 time the transfer exactly as grade 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (timing tables assume 10 ns) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a transfer (taken only when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 3 | Speed grade 0..4 (5..7 act as 4) |
| addr_i | input | AW | Transfer address |
| wdata_i | input | DW | Write data |
| bus_addr_o | output | AW | Address driven to the bus |
| bus_rd_n_o | output | 1 | Active-low read strobe |
| bus_wr_n_o | output | 1 | Active-low write strobe |
| bus_oe_o | output | 1 | Data driver enable |
| bus_wdata_o | output | DW | Data driven to the bus during writes |
| bus_rdata_i | input | DW | Data returned by the device |
| iordy_i | input | 1 | Device ready; low extends the strobe |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready-wait limit hit (with `done_o`) |

## Verification
The hold-off limit and the device's ready line can resolve in the same cycle. The bench provokes this by releasing ready exactly on the 125th wait edge, where a correct block ends the strobe without an error, and compares that against a release one edge later, which must raise the error. A completion and a new request also meet in one cycle: every transfer is issued on the very cycle the previous `done_o` is high, and the bench checks that it is taken and timed from that edge. A cycle-level reference model is compared on every clock, and per-transfer measurements of setup, low time and total length are compared against the grade tables.

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer #(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int CLK_NS      = 10,
  parameter int WAIT_MAX_NS = 1250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_n_o,
  output logic          bus_wr_n_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          iordy_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          err_o
);

  function automatic int clks(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int setup_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 70;
      3'd1:    return 50;
      3'd2:    return 30;
      3'd3:    return 30;
      default: return 25;
    endcase
  endfunction

  function automatic int pulse_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 165;
      3'd1:    return 125;
      3'd2:    return 100;
      3'd3:    return 80;
      default: return 70;
    endcase
  endfunction

  function automatic int cycle_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 600;
      3'd1:    return 383;
      3'd2:    return 240;
      3'd3:    return 180;
      default: return 120;
    endcase
  endfunction

  function automatic int recov_ns(input logic [2:0] m);
    case (m)
      3'd3:    return 70;
      3'd4:    return 25;
      default: return 0;
    endcase
  endfunction

  function automatic int ahold_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 20;
      3'd1:    return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int dhold_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 30;
      3'd1:    return 20;
      3'd2:    return 15;
      default: return 10;
    endcase
  endfunction

  localparam int WAIT_CLKS = clks(WAIT_MAX_NS);
  localparam int WW        = $clog2(WAIT_CLKS + 1);
  localparam int TW        = $clog2(clks(cycle_ns(3'd0)) + clks(pulse_ns(3'd0)) + WAIT_CLKS + 16) + 1;
  localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_REC} state_t;

  state_t        st;
  logic [2:0]    mode_q;
  logic          wr_q;
  logic          err_pend;
  logic [TW-1:0] cnt;
  logic [TW-1:0] rc;
  logic [WW-1:0] wcnt;

  logic [TW-1:0] su_m1, pw_m1, cyc_m1, rec_m1;
  int            rneed;

  always_comb begin
    rneed = clks(recov_ns(mode_q));
    if (clks(ahold_ns(mode_q)) > rneed) rneed = clks(ahold_ns(mode_q));
    if (clks(dhold_ns(mode_q)) > rneed) rneed = clks(dhold_ns(mode_q));
    if (rneed < 1) rneed = 1;
    su_m1  = TW'(clks(setup_ns(mode_q)) - 1);
    pw_m1  = TW'(clks(pulse_ns(mode_q)) - 1);
    cyc_m1 = TW'(clks(cycle_ns(mode_q)) - 1);
    rec_m1 = TW'(rneed - 1);
  end

  wire release_now = (cnt >= pw_m1) && (iordy_i || (wcnt == WAIT_LAST));
  wire finish_now  = (rc >= rec_m1) && (cnt >= cyc_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      mode_q      <= 3'd0;
      wr_q        <= 1'b0;
      err_pend    <= 1'b0;
      cnt         <= '0;
      rc          <= '0;
      wcnt        <= '0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_rd_n_o  <= 1'b1;
      bus_wr_n_o  <= 1'b1;
      bus_oe_o    <= 1'b0;
      rdata_o     <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_i) begin
            bus_addr_o  <= addr_i;
            bus_wdata_o <= wdata_i;
            wr_q        <= wr_i;
            mode_q      <= (mode_i > 3'd4) ? 3'd4 : mode_i;
            bus_oe_o    <= wr_i;
            cnt         <= '0;
            st          <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (cnt == su_m1) begin
            bus_rd_n_o <= wr_q;
            bus_wr_n_o <= !wr_q;
            cnt        <= '0;
            wcnt       <= '0;
            st         <= S_ACT;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        S_ACT: begin
          cnt <= cnt + TW'(1);
          if (release_now) begin
            bus_rd_n_o <= 1'b1;
            bus_wr_n_o <= 1'b1;
            if (!wr_q) rdata_o <= bus_rdata_i;
            err_pend   <= !iordy_i;
            rc         <= '0;
            st         <= S_REC;
          end else if (cnt >= pw_m1) begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: begin
          cnt <= cnt + TW'(1);
          rc  <= rc + TW'(1);
          if (finish_now) begin
            bus_oe_o <= 1'b0;
            done_o   <= 1'b1;
            err_o    <= err_pend;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end

endmodule

module pio_cycle_timer_chk #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_rd_n_o,
  input logic          bus_wr_n_o,
  input logic          bus_oe_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          done_o,
  input logic          err_o
);

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n_o && !bus_wr_n_o));

  // R6
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n_o |-> bus_oe_o);

  // R6
  read_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n_o |-> !bus_oe_o);

  // R6
  wdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_wdata_o));

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n_o || !bus_wr_n_o) |-> $stable(bus_addr_o));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bus_rd_n_o && bus_wr_n_o));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

endmodule

bind pio_cycle_timer pio_cycle_timer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr_o (bus_addr_o),
  .bus_rd_n_o (bus_rd_n_o),
  .bus_wr_n_o (bus_wr_n_o),
  .bus_oe_o   (bus_oe_o),
  .bus_wdata_o(bus_wdata_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/test_pio_cycle_timer.sv
module test_pio_cycle_timer;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int WAITC = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_i = 1'b0, wr_i = 1'b0, iordy_i = 1'b1;
  logic [2:0]    mode_i = 3'd0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0, bus_rdata_i = '0;
  logic [AW-1:0] bus_addr_o;
  logic          bus_rd_n_o, bus_wr_n_o, bus_oe_o, done_o, err_o;
  logic [DW-1:0] bus_wdata_o, rdata_o;

  pio_cycle_timer #(.AW(AW), .DW(DW)) i_pio_cycle_timer (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .mode_i(mode_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .bus_addr_o(bus_addr_o),
    .bus_rd_n_o(bus_rd_n_o), .bus_wr_n_o(bus_wr_n_o), .bus_oe_o(bus_oe_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .iordy_i(iordy_i),
    .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o));

  int n_tests = 0, n_fail = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int up10(input int ns); return (ns + 9) / 10; endfunction
  function automatic int g_su(input int m);
    int t[5] = '{70, 50, 30, 30, 25}; return up10(t[m]);
  endfunction
  function automatic int g_pw(input int m);
    int t[5] = '{165, 125, 100, 80, 70}; return up10(t[m]);
  endfunction
  function automatic int g_cyc(input int m);
    int t[5] = '{600, 383, 240, 180, 120}; return up10(t[m]);
  endfunction
  function automatic int g_q(input int m);
    int r[5] = '{0, 0, 0, 70, 25};
    int a[5] = '{20, 15, 10, 10, 10};
    int d[5] = '{30, 20, 15, 10, 10};
    int q = 1;
    if (up10(r[m]) > q) q = up10(r[m]);
    if (up10(a[m]) > q) q = up10(a[m]);
    if (up10(d[m]) > q) q = up10(d[m]);
    return q;
  endfunction

  // behavioural reference, advanced on each rising edge
  int m_st = 0, m_age = 0, m_low = 0, m_str = 0, m_tot = 0, m_rec = 0, m_mode = 0;
  bit m_wr = 0, m_perr = 0, m_rdn = 1, m_wrn = 1, m_oe = 0, m_done = 0, m_err = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rdn = 1; m_wrn = 1; m_oe = 0; m_done = 0; m_err = 0;
      m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      m_done = 0; m_err = 0;
      case (m_st)
        0: if (req_i) begin
             m_addr = addr_i; m_wd = wdata_i; m_wr = wr_i;
             m_mode = (mode_i > 3'd4) ? 4 : int'(mode_i);
             m_oe = wr_i; m_age = 0; m_st = 1;
           end
        1: begin
             m_age++;
             if (m_age == g_su(m_mode)) begin
               if (m_wr) m_wrn = 0; else m_rdn = 0;
               m_low = 0; m_str = 0; m_st = 2;
             end
           end
        2: begin
             m_low++;
             if (m_low >= g_pw(m_mode)) begin
               if (iordy_i || (m_str + 1 == WAITC)) begin
                 m_perr = !iordy_i;
                 if (!m_wr) m_rd = bus_rdata_i;
                 m_rdn = 1; m_wrn = 1; m_tot = m_low; m_rec = 0; m_st = 3;
               end else m_str++;
             end
           end
        default: begin
             m_rec++; m_tot++;
             if (m_rec >= g_q(m_mode) && m_tot >= g_cyc(m_mode)) begin
               m_done = 1; m_err = m_perr; m_oe = 0; m_st = 0;
             end
           end
      endcase
    end
  end

  always @(negedge clk) begin : cmp
    bit bad;
    if (rst_n) begin
      bad = 0;
      n_tests++;
      if (bus_rd_n_o !== m_rdn || bus_wr_n_o !== m_wrn) begin
        bad = 1; $display("FAIL R4 strobes actual=%0d%0d expected=%0d%0d", bus_rd_n_o, bus_wr_n_o, m_rdn, m_wrn);
      end
      if (bus_oe_o !== m_oe) begin bad = 1; $display("FAIL R6 oe actual=%0d expected=%0d", bus_oe_o, m_oe); end
      if (bus_addr_o !== m_addr) begin bad = 1; $display("FAIL R2 addr actual=%0d expected=%0d", bus_addr_o, m_addr); end
      if (bus_wdata_o !== m_wd) begin bad = 1; $display("FAIL R6 wdata actual=%0d expected=%0d", bus_wdata_o, m_wd); end
      if (rdata_o !== m_rd) begin bad = 1; $display("FAIL R9 rdata actual=%0d expected=%0d", rdata_o, m_rd); end
      if (done_o !== m_done) begin bad = 1; $display("FAIL R10 done actual=%0d expected=%0d", done_o, m_done); end
      if (err_o !== m_err) begin bad = 1; $display("FAIL R8 err actual=%0d expected=%0d", err_o, m_err); end
      if (bad) n_fail++;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd >= 100000) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=0", wd);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  logic [DW-1:0] rdv = 16'h5a00;

  // entered and left on a falling edge; issues the request at once
  task automatic run(input bit wr, input int mode, input int a, input int d,
                     input int hold_low, input bit poke);
    int em = (mode > 4) ? 4 : mode;
    string pre = (mode > 4) ? "R11 " : "";
    int exp_low, exp_tot, t = 0, low = 0, tot = 0, t_su = -1, guard = 0;
    bit fell = 0, seen = 0, drv_bad = 0, exp_err;
    logic [DW-1:0] last_v = '0;
    exp_low = (hold_low == 0) ? g_pw(em)
            : ((hold_low > g_pw(em)) ? hold_low : g_pw(em));
    if (exp_low > g_pw(em) + WAITC - 1) exp_low = g_pw(em) + WAITC - 1;
    exp_err = (hold_low > g_pw(em) + WAITC - 1);
    exp_tot = (exp_low + g_q(em) > g_cyc(em)) ? exp_low + g_q(em) : g_cyc(em);

    req_i = 1; wr_i = wr; mode_i = 3'(mode); addr_i = AW'(a); wdata_i = DW'(d);
    iordy_i = (hold_low == 0);
    @(negedge clk);
    req_i = 0;
    while (!seen && guard < 600) begin
      @(negedge clk);
      guard++;
      if (fell) tot++;
      if (!fell) begin
        t++;
        if (!bus_rd_n_o || !bus_wr_n_o) begin fell = 1; t_su = t; end
      end
      if (!bus_rd_n_o || !bus_wr_n_o) begin
        low++;
        if (wr && (!bus_oe_o || bus_wdata_o !== DW'(d) || !bus_rd_n_o)) drv_bad = 1;
        if (!wr && (bus_oe_o || !bus_wr_n_o)) drv_bad = 1;
        if (low == hold_low) iordy_i = 1;
        rdv = rdv + 16'h0123;
        bus_rdata_i = rdv;
        last_v = rdv;
        if (poke && low == 2) begin
          req_i = 1; addr_i = ~AW'(a); wr_i = ~wr; mode_i = 3'd0;
        end
        if (poke && low == 3) req_i = 0;
      end
      if (done_o) seen = 1;
    end
    check("R10 done seen", int'(seen), 1);
    check({pre, "R3 setup"}, t_su, g_su(em));
    check((hold_low == 0) ? {pre, "R4 width"} : (exp_err ? "R8 timeout width" : "R7 stretch width"),
          low, exp_low);
    check({pre, "R5 total"}, tot, exp_tot);
    check("R8 err flag", int'(err_o), int'(exp_err));
    check("R6 drive", int'(drv_bad), 0);
    check("R2 addr kept", int'(bus_addr_o), a % (1 << AW));
    if (!wr) check("R9 rdata", int'(rdata_o), int'(last_v));
    iordy_i = 1; req_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_n in reset", int'(bus_rd_n_o), 1);
    check("R1 oe in reset", int'(bus_oe_o), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 rd_n", int'(bus_rd_n_o), 1);
    check("R1 wr_n", int'(bus_wr_n_o), 1);
    check("R1 oe", int'(bus_oe_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 err", int'(err_o), 0);

    for (int m = 0; m < 5; m++) run(0, m, m + 1, 16'h1000 + m, 0, 0);
    for (int m = 0; m < 5; m++) run(1, m, m + 8, 16'h2200 + m, 0, 0);
    // R11 grades above 4
    for (int m = 5; m < 8; m++) run(0, m, m, 16'h3300, 0, 0);
    run(1, 7, 3, 16'hbeef, 0, 0);
    // R7 hold-off shorter than the limit
    run(0, 2, 5, 0, 20, 0);
    run(1, 4, 6, 16'h0f0f, 9, 0);
    run(0, 0, 7, 0, 5, 0);
    // R8 limit reached, and ready rising on the limit edge
    run(1, 1, 9, 16'h7777, 300, 0);
    run(0, 3, 10, 0, g_pw(3) + WAITC - 1, 0);
    run(0, 3, 11, 0, g_pw(3) + WAITC, 0);
    // R2 requests and grade changes during a transfer
    run(0, 4, 12, 0, 0, 1);
    run(1, 0, 13, 16'hc3c3, 0, 1);
    repeat (10) @(negedge clk);
    check("R10 no spurious done", int'(done_o), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule